// File: doc/BRIEF.md
# Peer connection message decoder

This block sits behind a connection manager that delivers a one-way stream of 64-bit signed messages, each tagged with a flag that says whether a handle came with it. It checks the fixed setup handshake and records what that handshake reveals. The handshake runs in this order: a protocol version, the local ID, a shared-memory announcement, then the vector lists of the peers already connected, then the list of local receive vectors. After the handshake, a peer ID that arrives with a handle connects that peer or adds a vector to it, and a peer ID without a handle disconnects it.

The decoder keeps the local ID, a count of connected receive vectors and a small table of peers with their vector counts. A query port reads that table. Vector counts never exceed the configured vector count, so extra handles are dropped and missing ones leave vectors unconnected. Any protocol violation closes the connection. The error output then stays set until reset, and every later message is consumed without effect.

Top module: `peer_msg_decoder`

## Requirements
- R1: `in_ready_o` is high at all times, so a message is consumed in the cycle where `in_valid_i` is high. Its effect on every registered output is visible after that clock edge, and no output changes in a cycle without a valid message.
- R2: The first message must be the value 0. Any other value sets `error_o`.
- R3: The second message is the local ID. It is accepted when bits 63..16 are all zero, and its low 16 bits then appear on `own_id_o`. Otherwise `error_o` is set.
- R4: The third message must be all ones (the value -1) with the handle flag set. This sets `shm_ready_o`, which stays set. Any other value, or a missing handle, sets `error_o`.
- R5: After the shared-memory message, a valid ID other than the local ID that arrives with a handle adds one vector to that peer. The count stops at `cfg_vectors_i`, and a new peer is given a free slot. `query_hit_o` and `query_vec_cnt_o` report the presence and count of the peer with ID `query_id_i`, and the count reads 0 on a miss.
- R6: After the shared-memory message, the local ID with a handle increments `rx_vec_cnt_o`, which stops at `cfg_vectors_i`.
- R7: Until setup completes, a message after the shared-memory message that has no handle or whose bits 63..16 are not all zero sets `error_o`.
- R8: `setup_done_o` sets on the first message that follows at least one local-ID setup message and is not itself the local ID with a handle. The peer connect or disconnect that this message carries is applied in the same cycle.
- R9: Once setup is complete, a peer ID without a handle removes that peer, so the query then shows no hit and a count of 0. A disconnect for an ID that is not in the table has no effect.
- R10: Once setup is complete, a message with bits 63..16 not all zero, or one carrying the local ID, sets `error_o`.
- R11: `error_o` stays set until reset. Later messages are still consumed, but they change neither the local ID, the flags, the receive count nor the peer table.
- R12: The table holds `NUM_SLOTS` peers. A connect for a new peer while the table is full is dropped without an error, and a slot freed by a disconnect can be reused.
- R13: After reset all outputs are 0, and no query hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Message present |
| in_ready_o | output | 1 | Message accepted (always high) |
| in_data_i | input | 64 | Signed message value |
| in_handle_i | input | 1 | Handle accompanies this message |
| cfg_vectors_i | input | VEC_W | Configured vector count |
| own_id_o | output | 16 | Local ID |
| shm_ready_o | output | 1 | Shared-memory message received |
| setup_done_o | output | 1 | Setup sequence complete |
| rx_vec_cnt_o | output | VEC_W | Connected receive vectors |
| query_id_i | input | 16 | Peer ID to look up |
| query_hit_o | output | 1 | Peer present in table |
| query_vec_cnt_o | output | VEC_W | Vector count of queried peer |
| error_o | output | 1 | Protocol error, connection closed |

## Verification
The first message after the receive-vector list does two jobs in one cycle: it completes setup, and it applies a peer disconnect (or connect) to the table. The bench provokes this by following the local-ID list directly with a handle-less peer ID. It then checks, after that same edge, that `setup_done_o` is set and that the peer has left the table. A second case sends a new-peer connect into a full table as the setup-completing message. Setup must complete, no error may be raised and the peer must not appear in the table.

// File: rtl/pmd_pkg.sv
package pmd_pkg;
  localparam int unsigned MSG_W = 64;
  localparam int unsigned ID_W  = 16;

  typedef enum logic [2:0] {
    ST_VER,
    ST_OWN,
    ST_SHM,
    ST_PEER,
    ST_SETUP,
    ST_RUN,
    ST_CLOSED
  } pmd_state_e;

  function automatic logic id_in_range(input logic [MSG_W-1:0] v);
    return v[MSG_W-1:ID_W] == '0;
  endfunction
endpackage

// File: rtl/pmd_sat_cnt.sv
module pmd_sat_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (inc_i && cnt_q < limit_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pmd_seq.sv
module pmd_seq
  import pmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             msg_vld_i,
  input  logic [MSG_W-1:0] msg_data_i,
  input  logic             msg_hdl_i,
  output logic [ID_W-1:0]  own_id_o,
  output logic             shm_ready_o,
  output logic             setup_done_o,
  output logic             error_o,
  output logic             peer_conn_o,
  output logic             peer_disc_o,
  output logic [ID_W-1:0]  peer_id_o,
  output logic             rx_inc_o
);
  pmd_state_e      state_q, state_d;
  logic [ID_W-1:0] own_q, own_d;
  logic            shm_q, shm_d, setup_q, setup_d, err_q, err_d;
  logic            in_rng, is_own;

  assign in_rng = id_in_range(msg_data_i);
  assign is_own = in_rng && (msg_data_i[ID_W-1:0] == own_q);

  always_comb begin
    state_d     = state_q;
    own_d       = own_q;
    shm_d       = shm_q;
    setup_d     = setup_q;
    err_d       = err_q;
    peer_conn_o = 1'b0;
    peer_disc_o = 1'b0;
    rx_inc_o    = 1'b0;
    if (msg_vld_i) begin
      unique case (state_q)
        ST_VER: begin
          if (msg_data_i != '0) begin err_d = 1'b1; state_d = ST_CLOSED; end
          else state_d = ST_OWN;
        end
        ST_OWN: begin
          if (!in_rng) begin err_d = 1'b1; state_d = ST_CLOSED; end
          else begin own_d = msg_data_i[ID_W-1:0]; state_d = ST_SHM; end
        end
        ST_SHM: begin
          if (msg_data_i != '1 || !msg_hdl_i) begin err_d = 1'b1; state_d = ST_CLOSED; end
          else begin shm_d = 1'b1; state_d = ST_PEER; end
        end
        ST_PEER: begin
          if (!msg_hdl_i || !in_rng) begin err_d = 1'b1; state_d = ST_CLOSED; end
          else if (is_own) begin rx_inc_o = 1'b1; state_d = ST_SETUP; end
          else peer_conn_o = 1'b1;
        end
        ST_SETUP: begin
          if (is_own && msg_hdl_i) rx_inc_o = 1'b1;
          else if (!in_rng || is_own) begin err_d = 1'b1; state_d = ST_CLOSED; end
          else begin
            // first steady-state message: completes setup and is applied
            setup_d     = 1'b1;
            state_d     = ST_RUN;
            peer_conn_o = msg_hdl_i;
            peer_disc_o = !msg_hdl_i;
          end
        end
        ST_RUN: begin
          if (!in_rng || is_own) begin err_d = 1'b1; state_d = ST_CLOSED; end
          else begin
            peer_conn_o = msg_hdl_i;
            peer_disc_o = !msg_hdl_i;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_VER;
      own_q   <= '0;
      shm_q   <= 1'b0;
      setup_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      own_q   <= own_d;
      shm_q   <= shm_d;
      setup_q <= setup_d;
      err_q   <= err_d;
    end
  end

  assign own_id_o     = own_q;
  assign shm_ready_o  = shm_q;
  assign setup_done_o = setup_q;
  assign error_o      = err_q;
  assign peer_id_o    = msg_data_i[ID_W-1:0];
endmodule

// File: rtl/pmd_peer_table.sv
module pmd_peer_table #(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned ID_W      = 16,
  parameter int unsigned VEC_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conn_i,
  input  logic             disc_i,
  input  logic [ID_W-1:0]  upd_id_i,
  input  logic [VEC_W-1:0] limit_i,
  input  logic [ID_W-1:0]  query_id_i,
  output logic             query_hit_o,
  output logic [VEC_W-1:0] query_cnt_o
);
  logic [NUM_SLOTS-1:0] slot_vld;
  logic [ID_W-1:0]      slot_id  [NUM_SLOTS];
  logic [VEC_W-1:0]     slot_cnt [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] upd_hit, free_oh;
  logic                 any_hit;
  logic                 taken;

  always_comb begin
    free_oh = '0;
    taken   = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      upd_hit[i] = slot_vld[i] && (slot_id[i] == upd_id_i);
      free_oh[i] = !slot_vld[i] && !taken;
      taken      = taken | !slot_vld[i];
    end
  end
  assign any_hit = |upd_hit;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_vld[g] <= 1'b0;
        slot_id[g]  <= '0;
        slot_cnt[g] <= '0;
      end else if (conn_i) begin
        if (upd_hit[g]) begin
          if (slot_cnt[g] < limit_i) slot_cnt[g] <= slot_cnt[g] + 1'b1;
        end else if (!any_hit && free_oh[g]) begin
          slot_vld[g] <= 1'b1;
          slot_id[g]  <= upd_id_i;
          slot_cnt[g] <= (limit_i != '0) ? VEC_W'(1) : '0;
        end
      end else if (disc_i && upd_hit[g]) begin
        slot_vld[g] <= 1'b0;
        slot_cnt[g] <= '0;
      end
    end
  end

  always_comb begin
    query_hit_o = 1'b0;
    query_cnt_o = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (slot_vld[i] && slot_id[i] == query_id_i) begin
        query_hit_o = 1'b1;
        query_cnt_o = slot_cnt[i];
      end
    end
  end
endmodule

// File: rtl/peer_msg_decoder.sv
module peer_msg_decoder
  import pmd_pkg::*;
#(
  parameter int unsigned VEC_W     = 4,
  parameter int unsigned NUM_SLOTS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [63:0]      in_data_i,
  input  logic             in_handle_i,
  input  logic [VEC_W-1:0] cfg_vectors_i,
  output logic [15:0]      own_id_o,
  output logic             shm_ready_o,
  output logic             setup_done_o,
  output logic [VEC_W-1:0] rx_vec_cnt_o,
  input  logic [15:0]      query_id_i,
  output logic             query_hit_o,
  output logic [VEC_W-1:0] query_vec_cnt_o,
  output logic             error_o
);
  logic            peer_conn, peer_disc, rx_inc;
  logic [ID_W-1:0] peer_id;

  assign in_ready_o = 1'b1;

  pmd_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .msg_vld_i    (in_valid_i),
    .msg_data_i   (in_data_i),
    .msg_hdl_i    (in_handle_i),
    .own_id_o     (own_id_o),
    .shm_ready_o  (shm_ready_o),
    .setup_done_o (setup_done_o),
    .error_o      (error_o),
    .peer_conn_o  (peer_conn),
    .peer_disc_o  (peer_disc),
    .peer_id_o    (peer_id),
    .rx_inc_o     (rx_inc)
  );

  pmd_sat_cnt #(.W(VEC_W)) u_rx_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (rx_inc),
    .limit_i (cfg_vectors_i),
    .cnt_o   (rx_vec_cnt_o)
  );

  pmd_peer_table #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W), .VEC_W(VEC_W)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .conn_i      (peer_conn),
    .disc_i      (peer_disc),
    .upd_id_i    (peer_id),
    .limit_i     (cfg_vectors_i),
    .query_id_i  (query_id_i),
    .query_hit_o (query_hit_o),
    .query_cnt_o (query_vec_cnt_o)
  );
endmodule

// File: rtl/pmd_checker.sv
module pmd_checker #(
  parameter int unsigned VEC_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic [VEC_W-1:0] cfg_vectors_i,
  input logic [15:0]      own_id_o,
  input logic             shm_ready_o,
  input logic             setup_done_o,
  input logic [VEC_W-1:0] rx_vec_cnt_o,
  input logic             query_hit_o,
  input logic [VEC_W-1:0] query_vec_cnt_o,
  input logic             error_o
);
  a_r11_error_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> error_o);

  a_r11_state_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> ($stable(own_id_o) && $stable(rx_vec_cnt_o) && $stable(setup_done_o)
                 && $stable(shm_ready_o)));

  a_r4_shm_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shm_ready_o |=> shm_ready_o);

  a_r8_setup_after_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_done_o |-> (shm_ready_o && (rx_vec_cnt_o != '0 || cfg_vectors_i == '0)));

  a_r6_rx_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_vec_cnt_o <= cfg_vectors_i);

  a_r5_query_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    query_hit_o |-> query_vec_cnt_o <= cfg_vectors_i);

  a_r5_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !query_hit_o |-> query_vec_cnt_o == '0);

  a_r1_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(own_id_o) && $stable(shm_ready_o) && $stable(setup_done_o)
                     && $stable(error_o) && $stable(rx_vec_cnt_o)));
endmodule

bind peer_msg_decoder pmd_checker #(.VEC_W(VEC_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .in_valid_i      (in_valid_i),
  .cfg_vectors_i   (cfg_vectors_i),
  .own_id_o        (own_id_o),
  .shm_ready_o     (shm_ready_o),
  .setup_done_o    (setup_done_o),
  .rx_vec_cnt_o    (rx_vec_cnt_o),
  .query_hit_o     (query_hit_o),
  .query_vec_cnt_o (query_vec_cnt_o),
  .error_o         (error_o)
);

// File: tb/sim_peer_msg_decoder.sv
module sim_peer_msg_decoder;
  localparam int unsigned VEC_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [63:0]      in_data = '0;
  logic             in_handle = 1'b0;
  logic [VEC_W-1:0] cfg_vec = 4'd3;
  logic [15:0]      query_id = '0;
  logic             in_ready, shm_ready, setup_done, query_hit, error;
  logic [15:0]      own_id;
  logic [VEC_W-1:0] rx_cnt, query_cnt;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  peer_msg_decoder #(.VEC_W(VEC_W), .NUM_SLOTS(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .in_handle_i(in_handle), .cfg_vectors_i(cfg_vec),
    .own_id_o(own_id), .shm_ready_o(shm_ready), .setup_done_o(setup_done),
    .rx_vec_cnt_o(rx_cnt), .query_id_i(query_id), .query_hit_o(query_hit),
    .query_vec_cnt_o(query_cnt), .error_o(error)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    rst_n    = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input logic [63:0] d, input logic h);
    @(negedge clk);
    in_data   = d;
    in_handle = h;
    in_valid  = 1'b1;
    @(negedge clk);
    in_valid  = 1'b0;
  endtask

  task automatic query(input string req, input logic [15:0] id, input logic hit,
                       input logic [VEC_W-1:0] cnt);
    query_id = id;
    #1;
    chk({req, " hit"}, 64'(query_hit), 64'(hit));
    chk({req, " cnt"}, 64'(query_cnt), 64'(cnt));
  endtask

  task automatic handshake(input logic [15:0] id);
    send(64'd0, 1'b0);
    send(64'(id), 1'b0);
    send('1, 1'b1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R13 own", 64'(own_id), 0);
    chk("R13 shm", 64'(shm_ready), 0);
    chk("R13 setup", 64'(setup_done), 0);
    chk("R13 rx", 64'(rx_cnt), 0);
    chk("R13 err", 64'(error), 0);
    query("R13 query", 16'd0, 1'b0, '0);
    chk("R1 ready", 64'(in_ready), 1);
  endtask

  task automatic t_bad_version();
    do_reset();
    send(64'd5, 1'b0);
    chk("R2 bad version", 64'(error), 1);
    send(64'd0, 1'b0);
    send(64'd9, 1'b0);
    chk("R11 err held", 64'(error), 1);
    chk("R11 own unchanged", 64'(own_id), 0);
    chk("R1 ready after close", 64'(in_ready), 1);
  endtask

  task automatic t_bad_id();
    do_reset();
    send(64'd0, 1'b0);
    chk("R2 version ok", 64'(error), 0);
    send(64'h1_0000, 1'b0);
    chk("R3 id out of range", 64'(error), 1);
    do_reset();
    send(64'd0, 1'b0);
    send(64'hFFFF, 1'b0);
    chk("R3 max id", 64'(own_id), 64'hFFFF);
    chk("R3 max id no err", 64'(error), 0);
  endtask

  task automatic t_bad_shm();
    do_reset();
    send(64'd0, 1'b0);
    send(64'd7, 1'b0);
    send('1, 1'b0);
    chk("R4 missing handle", 64'(error), 1);
    chk("R4 shm not set", 64'(shm_ready), 0);
    do_reset();
    send(64'd0, 1'b0);
    send(64'd7, 1'b0);
    send(64'hFFFF_FFFF_FFFF_FFFE, 1'b1);
    chk("R4 wrong value", 64'(error), 1);
  endtask

  task automatic t_main();
    do_reset();
    handshake(16'd7);
    chk("R3 own id", 64'(own_id), 7);
    chk("R4 shm ready", 64'(shm_ready), 1);
    send(64'd3, 1'b1);
    send(64'd3, 1'b1);
    for (int i = 0; i < 4; i++) send(64'd9, 1'b1);
    query("R5 peer3", 16'd3, 1'b1, 4'd2);
    query("R5 peer9 saturated", 16'd9, 1'b1, 4'd3);
    for (int i = 0; i < 4; i++) send(64'd7, 1'b1);
    chk("R6 rx saturated", 64'(rx_cnt), 3);
    chk("R8 not yet done", 64'(setup_done), 0);
    send(64'd3, 1'b0);
    chk("R8 setup done", 64'(setup_done), 1);
    query("R9 peer3 removed same cycle", 16'd3, 1'b0, '0);
    send(64'd20, 1'b0);
    chk("R9 unknown disc no err", 64'(error), 0);
    query("R9 peer9 kept", 16'd9, 1'b1, 4'd3);
    send(64'd5, 1'b1);
    query("R5 run connect", 16'd5, 1'b1, 4'd1);
    send(64'd7, 1'b1);
    chk("R10 own id in run", 64'(error), 1);
    send(64'd9, 1'b0);
    query("R11 table frozen", 16'd9, 1'b1, 4'd3);
    chk("R11 rx frozen", 64'(rx_cnt), 3);
  endtask

  task automatic t_table_full();
    do_reset();
    handshake(16'd0);
    for (int i = 1; i <= 4; i++) send(64'(i), 1'b1);
    send(64'd0, 1'b1);
    send(64'd5, 1'b1);
    chk("R12 setup done on full", 64'(setup_done), 1);
    chk("R12 no err", 64'(error), 0);
    query("R12 peer5 dropped", 16'd5, 1'b0, '0);
    send(64'd2, 1'b0);
    send(64'd5, 1'b1);
    query("R12 slot reused", 16'd5, 1'b1, 4'd1);
    query("R12 peer4 kept", 16'd4, 1'b1, 4'd1);
    send(64'h1_0000_0000, 1'b1);
    chk("R10 range in run", 64'(error), 1);
  endtask

  task automatic t_setup_handle();
    do_reset();
    handshake(16'd2);
    send(64'd4, 1'b0);
    chk("R7 missing handle in setup", 64'(error), 1);
    do_reset();
    handshake(16'd2);
    send(64'h2_0004, 1'b1);
    chk("R7 range in setup", 64'(error), 1);
    query("R7 nothing added", 16'd4, 1'b0, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_bad_version();
    t_bad_id();
    t_bad_shm();
    t_main();
    t_table_full();
    t_setup_handle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule